// File: doc/BRIEF.md
# Mode-Banked General Register File

This block is the general-purpose register file of a 32-bit core that runs in several privilege modes. Software sees sixteen registers, indexed 0 to 15. Depending on a 5-bit mode value, some of those indices are redirected to private physical copies. The interrupt-style modes thereby get their own stack and link registers without any save or restore sequence. The file has two combinational read ports and one clocked write port. It also keeps one saved-status word for each exception mode, which can be read and written through a port that always addresses the current mode's copy.

A mode change only changes the index-to-storage mapping. No data moves. Returning to a mode therefore finds its private registers exactly as they were left. The fast-interrupt mode redirects the most indices (8 through 14), so its handler can run without touching the shared upper registers. The other exception modes redirect only 13 and 14. User mode, system mode and every unassigned mode code use the shared set and have no saved-status word.

Top module: `banked_regfile`

## Requirements
- R1: After reset the mode output is 0x13 (supervisor). Every register reads zero on both read ports, and the saved-status read is zero.
- R2: The bank is chosen by mode bits [3:0] only, and bit 4 plays no part in the choice. The codes are: 0x1 fast interrupt, 0x2 interrupt, 0x3 supervisor, 0x7 abort, 0xB undefined. Every other code (for example 0x0 user, 0xF system, or the reserved 0x4) selects the shared set.
- R3: In fast-interrupt mode, indices 8 to 14 address seven private registers. Writes to them leave the shared copies unchanged, and the shared copies leave them unchanged.
- R4: In interrupt, supervisor, abort and undefined modes, indices 13 and 14 address a private pair for each mode. Indices 8 to 12 stay shared with user mode.
- R5: Indices 0 to 7 and index 15 are never redirected. The same physical register is seen in every mode.
- R6: Both read ports are combinational and independent of each other. A write of `wr_data` to `wr_idx` with `wr_en` high is visible on the read ports after the next rising clock edge.
- R7: Each of the five exception modes owns a separate saved-status word. `sts_wr_en` writes the current mode's word, and `sts_rd_data` shows it.
- R8: In a mode with no saved-status word (user, system, reserved codes), `sts_rd_data` reads zero and `sts_wr_en` changes no stored status word.
- R9: When a register write and a mode change fall in the same cycle, the write lands in the bank of the mode that was current before that edge.
- R10: `mode_wr_en` loads `mode_in` into the mode register at the rising edge, and the new value appears on `mode_out`. Loading the current mode again changes nothing, and private registers keep their contents across any mode switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_wr_en | input | 1 | Load `mode_in` into the mode register |
| mode_in | input | 5 | New mode value |
| mode_out | output | 5 | Current mode value |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| sts_wr_en | input | 1 | Saved-status write enable for the current mode |
| sts_wr_data | input | 32 | Saved-status write data |
| sts_rd_data | output | 32 | Saved-status word of the current mode, zero if none |

## Verification
The assertions assume that every input is a known value at each rising edge while reset is released. They do not assume that index 15 has any special meaning. The write-landing check also assumes that a write and a mode change may coincide, so it checks the slot picked under the old mode. The directed stimulus changes inputs only on falling edges, keeps every enable low between operations, and uses each mode code only as a whole 5-bit value. Reserved codes are included on purpose.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;

  typedef enum logic [2:0] {
    BK_SHARED = 3'd0,
    BK_FAST   = 3'd1,
    BK_IRQ    = 3'd2,
    BK_SUPV   = 3'd3,
    BK_ABORT  = 3'd4,
    BK_UNDEF  = 3'd5
  } bank_e;

  localparam int NUM_STS_BANKS  = 5;
  localparam int NUM_PAIR_BANKS = 4;

  function automatic bank_e bank_of(input logic [3:0] code);
    bank_e b;
    case (code)
      4'h1:    b = BK_FAST;
      4'h2:    b = BK_IRQ;
      4'h3:    b = BK_SUPV;
      4'h7:    b = BK_ABORT;
      4'hB:    b = BK_UNDEF;
      default: b = BK_SHARED;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/rb_reset_sync.sv
module rb_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rb_mode_reg.sv
module rb_mode_reg #(
  parameter int          MODE_W     = 5,
  parameter logic [4:0]  RESET_MODE = 5'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [MODE_W-1:0] mode_in,
  output logic [MODE_W-1:0] mode_q
);
  logic [MODE_W-1:0] mode_d;

  always_comb begin
    mode_d = mode_q;
    if (ld_en) mode_d = mode_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_W'(RESET_MODE);
    else        mode_q <= mode_d;
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> $stable(mode_q)); // R10
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (mode_q == $past(mode_in))); // R10
endmodule

// File: rtl/rb_slot_map.sv
module rb_slot_map
  import banked_rf_pkg::*;
#(
  parameter int NREG    = 16,
  parameter int FAST_LO = 8,
  parameter int PAIR_LO = 13,
  localparam int IDX_W    = $clog2(NREG),
  localparam int BANK_TOP = NREG - 2,
  localparam int FAST_CNT = BANK_TOP - FAST_LO + 1,
  localparam int PAIR_CNT = BANK_TOP - PAIR_LO + 1,
  localparam int TOTAL    = NREG + FAST_CNT + NUM_PAIR_BANKS * PAIR_CNT,
  localparam int SLOT_W   = $clog2(TOTAL)
) (
  input  bank_e             bank,
  input  logic [IDX_W-1:0]  idx,
  output logic [SLOT_W-1:0] slot
);
  int idx_i;
  int slot_i;

  always_comb begin
    idx_i  = int'(idx);
    slot_i = idx_i;
    if (bank == BK_FAST && idx_i >= FAST_LO && idx_i <= BANK_TOP) begin
      slot_i = NREG + idx_i - FAST_LO;
    end else if (bank != BK_SHARED && bank != BK_FAST &&
                 idx_i >= PAIR_LO && idx_i <= BANK_TOP) begin
      slot_i = NREG + FAST_CNT + (int'(bank) - int'(BK_IRQ)) * PAIR_CNT
             + idx_i - PAIR_LO;
    end
    slot = SLOT_W'(slot_i);
  end
endmodule

// File: rtl/rb_gpr_store.sv
module rb_gpr_store #(
  parameter int XLEN   = 32,
  parameter int TOTAL  = 31,
  localparam int SLOT_W = $clog2(TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [XLEN-1:0]   wr_data,
  input  logic [SLOT_W-1:0] rd_a_slot,
  output logic [XLEN-1:0]   rd_a_data,
  input  logic [SLOT_W-1:0] rd_b_slot,
  output logic [XLEN-1:0]   rd_b_data
);
  logic [XLEN-1:0] mem_q [TOTAL];
  logic [XLEN-1:0] mem_d [TOTAL];

  always_comb begin
    for (int i = 0; i < TOTAL; i++) mem_d[i] = mem_q[i];
    if (wr_en) mem_d[wr_slot] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < TOTAL; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rd_a_data = mem_q[rd_a_slot];
  assign rd_b_data = mem_q[rd_b_slot];

  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_slot) < TOTAL)); // R6
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem_q[$past(wr_slot)] == $past(wr_data))); // R9
endmodule

// File: rtl/rb_status_store.sv
module rb_status_store
  import banked_rf_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  bank_e           bank,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] rd_data
);
  logic [NUM_STS_BANKS-1:0][XLEN-1:0] sts_q;
  logic [NUM_STS_BANKS-1:0][XLEN-1:0] sts_d;
  logic has_sts;
  int   sel;

  always_comb begin
    has_sts = (bank != BK_SHARED);
    sel     = has_sts ? (int'(bank) - 1) : 0;
  end

  always_comb begin
    sts_d = sts_q;
    if (wr_en && has_sts) sts_d[sel] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign rd_data = has_sts ? sts_q[sel] : '0;

  AST_NOSTS_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bank == BK_SHARED) |=> $stable(sts_q)); // R8
  AST_STS_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bank != BK_SHARED) |=> (rd_data == $past(wr_data) || bank != $past(bank))); // R7
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_rf_pkg::*;
#(
  parameter int         XLEN       = 32,
  parameter int         NREG       = 16,
  parameter int         FAST_LO    = 8,
  parameter int         PAIR_LO    = 13,
  parameter logic [4:0] RESET_MODE = 5'h13,
  localparam int IDX_W    = $clog2(NREG),
  localparam int BANK_TOP = NREG - 2,
  localparam int FAST_CNT = BANK_TOP - FAST_LO + 1,
  localparam int PAIR_CNT = BANK_TOP - PAIR_LO + 1,
  localparam int TOTAL    = NREG + FAST_CNT + NUM_PAIR_BANKS * PAIR_CNT,
  localparam int SLOT_W   = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr_en,
  input  logic [4:0]       mode_in,
  output logic [4:0]       mode_out,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [XLEN-1:0]  rd_a_data,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [XLEN-1:0]  rd_b_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             sts_wr_en,
  input  logic [XLEN-1:0]  sts_wr_data,
  output logic [XLEN-1:0]  sts_rd_data
);
  logic              rst_sync_n;
  logic [4:0]        mode_q;
  bank_e             cur_bank;
  logic [SLOT_W-1:0] slot_a, slot_b, slot_w;

  rb_reset_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  rb_mode_reg #(.MODE_W(5), .RESET_MODE(RESET_MODE)) u_mode (
    .clk(clk), .rst_n(rst_sync_n), .ld_en(mode_wr_en),
    .mode_in(mode_in), .mode_q(mode_q));

  assign cur_bank = bank_of(mode_q[3:0]);
  assign mode_out = mode_q;

  rb_slot_map #(.NREG(NREG), .FAST_LO(FAST_LO), .PAIR_LO(PAIR_LO)) u_map_a (
    .bank(cur_bank), .idx(rd_a_idx), .slot(slot_a));
  rb_slot_map #(.NREG(NREG), .FAST_LO(FAST_LO), .PAIR_LO(PAIR_LO)) u_map_b (
    .bank(cur_bank), .idx(rd_b_idx), .slot(slot_b));
  rb_slot_map #(.NREG(NREG), .FAST_LO(FAST_LO), .PAIR_LO(PAIR_LO)) u_map_w (
    .bank(cur_bank), .idx(wr_idx), .slot(slot_w));

  rb_gpr_store #(.XLEN(XLEN), .TOTAL(TOTAL)) u_gpr (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_slot(slot_w), .wr_data(wr_data),
    .rd_a_slot(slot_a), .rd_a_data(rd_a_data),
    .rd_b_slot(slot_b), .rd_b_data(rd_b_data));

  rb_status_store #(.XLEN(XLEN)) u_sts (
    .clk(clk), .rst_n(rst_sync_n), .bank(cur_bank),
    .wr_en(sts_wr_en), .wr_data(sts_wr_data), .rd_data(sts_rd_data));

  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data)); // R6
  AST_LOW_UNBANKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && int'(wr_idx) < FAST_LO) |-> (int'(slot_w) == int'(wr_idx))); // R5
  AST_STS_ZERO_WHEN_NONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bank_of(mode_out[3:0]) == BK_SHARED) |-> (sts_rd_data == '0)); // R8
endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_wr_en;
  logic [4:0]  mode_in;
  logic [4:0]  mode_out;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, sts_wr_en;
  logic [31:0] sts_wr_data, sts_rd_data;

  int errs   = 0;
  int checks = 0;

  always #5 clk = ~clk;

  banked_regfile uut (
    .clk(clk), .rst_n(rst_n), .mode_wr_en(mode_wr_en), .mode_in(mode_in),
    .mode_out(mode_out), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .sts_wr_en(sts_wr_en),
    .sts_wr_data(sts_wr_data), .sts_rd_data(sts_rd_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [4:0] m);
    @(negedge clk); mode_wr_en = 1'b1; mode_in = m;
    @(negedge clk); mode_wr_en = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_idx = 4'(idx); wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic sts_wr(input logic [31:0] v);
    @(negedge clk); sts_wr_en = 1'b1; sts_wr_data = v;
    @(negedge clk); sts_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int idx, input logic [31:0] exp);
    rd_a_idx = 4'(idx); rd_b_idx = 4'(idx);
    #1;
    chk(req, rd_a_data, exp);
    chk(req, rd_b_data, exp);
  endtask

  task automatic t_reset;
    chk("R1 mode", 32'(mode_out), 32'h13);
    for (int i = 0; i < 16; i++) rd_chk("R1 reg", i, 32'h0);
    chk("R1 sts", sts_rd_data, 32'h0);
  endtask

  task automatic t_low_shared;
    set_mode(5'h10);
    for (int i = 0; i < 8; i++) wr(i, 32'h100 + i);
    wr(15, 32'h10F);
    rd_chk("R6 readback", 5, 32'h105);
    set_mode(5'h11);
    for (int i = 0; i < 8; i++) rd_chk("R5 fast", i, 32'h100 + i);
    rd_chk("R5 idx15", 15, 32'h10F);
    wr(3, 32'hF3);
    set_mode(5'h1B);
    rd_chk("R5 undef", 3, 32'hF3);
    rd_chk("R5 idx15", 15, 32'h10F);
  endtask

  task automatic t_fast;
    set_mode(5'h10);
    for (int i = 8; i < 15; i++) wr(i, 32'h200 + i);
    set_mode(5'h11);
    for (int i = 8; i < 15; i++) rd_chk("R3 private fresh", i, 32'h0);
    for (int i = 8; i < 15; i++) wr(i, 32'h300 + i);
    set_mode(5'h10);
    for (int i = 8; i < 15; i++) rd_chk("R3 shared kept", i, 32'h200 + i);
    set_mode(5'h11);
    for (int i = 8; i < 15; i++) rd_chk("R3 private kept", i, 32'h300 + i);
  endtask

  task automatic t_bit4;
    set_mode(5'h01);
    rd_chk("R2 bit4 ignored", 8, 32'h308);
    rd_chk("R2 bit4 ignored", 13, 32'h30D);
    set_mode(5'h0F);
    rd_chk("R2 system shared", 8, 32'h208);
  endtask

  task automatic t_pairs;
    logic [4:0] ml [4] = '{5'h12, 5'h13, 5'h17, 5'h1B};
    for (int k = 0; k < 4; k++) begin
      set_mode(ml[k]);
      rd_chk("R4 shared 8", 8, 32'h208);
      rd_chk("R4 shared 12", 12, 32'h20C);
      rd_chk("R4 pair fresh", 13, 32'h0);
      wr(13, 32'h400 + 16 * k);
      wr(14, 32'h401 + 16 * k);
    end
    for (int k = 0; k < 4; k++) begin
      set_mode(ml[k]);
      rd_chk("R4 pair 13", 13, 32'h400 + 16 * k);
      rd_chk("R4 pair 14", 14, 32'h401 + 16 * k);
    end
    set_mode(5'h10);
    rd_chk("R4 user 13", 13, 32'h20D);
    rd_chk("R4 user 14", 14, 32'h20E);
  endtask

  task automatic t_sts;
    logic [4:0] ml [5] = '{5'h11, 5'h12, 5'h13, 5'h17, 5'h1B};
    for (int k = 0; k < 5; k++) begin
      set_mode(ml[k]);
      sts_wr(32'h500 + k);
      chk("R7 sts write", sts_rd_data, 32'h500 + k);
    end
    for (int k = 0; k < 5; k++) begin
      set_mode(ml[k]);
      #1 chk("R7 sts kept", sts_rd_data, 32'h500 + k);
    end
  endtask

  task automatic t_nosts;
    logic [4:0] ml [4] = '{5'h10, 5'h1F, 5'h14, 5'h00};
    for (int k = 0; k < 4; k++) begin
      set_mode(ml[k]);
      #1 chk("R8 sts zero", sts_rd_data, 32'h0);
      sts_wr(32'hDEAD0000 + k);
      #1 chk("R8 sts write ignored", sts_rd_data, 32'h0);
    end
    set_mode(5'h14);
    rd_chk("R2 reserved shared", 13, 32'h20D);
    for (int k = 0; k < 5; k++) begin
      logic [4:0] el [5] = '{5'h11, 5'h12, 5'h13, 5'h17, 5'h1B};
      set_mode(el[k]);
      #1 chk("R8 banked sts untouched", sts_rd_data, 32'h500 + k);
    end
  endtask

  task automatic t_same_cycle;
    set_mode(5'h10);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h600;
    mode_wr_en = 1'b1; mode_in = 5'h12;
    @(negedge clk);
    wr_en = 1'b0; mode_wr_en = 1'b0;
    chk("R10 mode_out", 32'(mode_out), 32'h12);
    rd_chk("R9 new bank untouched", 13, 32'h400);
    set_mode(5'h10);
    rd_chk("R9 old bank written", 13, 32'h600);
  endtask

  task automatic t_mode;
    set_mode(5'h10);
    chk("R10 same mode", 32'(mode_out), 32'h10);
    rd_chk("R10 same mode regs", 13, 32'h600);
    set_mode(5'h17);
    chk("R10 mode_out", 32'(mode_out), 32'h17);
    rd_chk("R10 pair kept", 13, 32'h420);
    set_mode(5'h17);
    rd_chk("R10 same mode regs", 14, 32'h421);
    #1 chk("R10 same mode sts", sts_rd_data, 32'h503);
  endtask

  task automatic t_ports;
    set_mode(5'h10);
    rd_a_idx = 4'd3; rd_b_idx = 4'd13;
    #1;
    chk("R6 port a", rd_a_data, 32'hF3);
    chk("R6 port b", rd_b_data, 32'h600);
    rd_a_idx = 4'd9; rd_b_idx = 4'd0;
    #1;
    chk("R6 port a", rd_a_data, 32'h209);
    chk("R6 port b", rd_b_data, 32'h100);
  endtask

  initial begin
    #2_000_000;
    checks++; errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_wr_en = 1'b0; mode_in = '0;
    rd_a_idx = '0; rd_b_idx = '0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    sts_wr_en = 1'b0; sts_wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_low_shared;
    t_fast;
    t_bit4;
    t_pairs;
    t_sts;
    t_nosts;
    t_same_cycle;
    t_mode;
    t_ports;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule